// File: doc/BRIEF.md
# Serial EEPROM Slave over I2C

This block is an I2C target that looks to a bus master like a small serial EEPROM with 256 bytes of 8 bits. SCL and SDA are brought into the system clock domain through two-stage synchronisers. The block then finds START and STOP conditions, takes in a control byte, and either accepts a write or serves a read. SDA is never driven high. The block only pulls the line low through an output-enable, and the pad and pull-up stay outside.

A write carries a word address and then any number of data bytes. The data bytes collect in a 16-deep staging ring, and only the newest 16 survive. When the master sends STOP, the kept bytes are copied into the byte array at consecutive addresses. A programming interval then starts, lasting a parameterised number of system clocks. During that interval the block answers nothing on the bus. Reads return bytes from an internal pointer that advances after every byte. A random read is made with a dummy write that carries only the address, followed by a repeated START.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) begins a new transaction from any state, including in the middle of a byte. A rising SDA while SCL is high (STOP) ends the transaction and releases SDA.
- R2: A control byte whose bits 7:4 equal 1010 is acknowledged, whatever bits 3:1 hold; bit 0 set to 1 selects a read and 0 a write. Any other upper nibble is not acknowledged, and the bus is then ignored until the next START.
- R3: For every accepted control byte, address byte and write data byte, the slave holds SDA low through the whole high phase of the ninth clock. It releases SDA after that clock falls.
- R4: In a write, the byte after the control byte is the word address, and the bytes after it are data, sent MSB first. On STOP after at least one data byte, the kept bytes are stored at the word address and the addresses after it, modulo 256. The pointer then equals the word address plus the number of kept bytes.
- R5: When more than 16 data bytes arrive, only the last 16 are kept. The oldest of those kept bytes is stored at the word address.
- R6: A write that carries only the address byte sets the pointer. It starts no programming interval, so the next control byte is acknowledged at once.
- R7: A read returns the byte at the pointer, MSB first, and the pointer advances by one after each byte, wrapping from 255 to 0. The pointer carries across transactions.
- R8: If the master does not acknowledge a read byte, the read ends and SDA stays released until the next START or STOP.
- R9: For PROG_CYCLES system clocks after a commit, no control byte is acknowledged, and bytes sent during that time leave the memory unchanged.
- R10: After reset, SDA is released, every memory byte is 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad (wired-AND level) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Every reaction to a bus edge arrives on the third system clock after the pin changes: two clocks of synchronisation and one of registered action. The bench therefore samples SDA six clocks after SCL falls, which is well after the slave has updated its data or acknowledge. Each high phase is sampled at three points, so an acknowledge that drops out early is caught. Memory is committed in the same clock that the STOP is recognised. The bench probes the busy window with a control byte sent straight after STOP, and that byte arrives long before PROG_CYCLES has elapsed. The bench then waits PROG_CYCLES plus a margin before it reads back.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int PROG_CYCLES = 500000,
  parameter int BUF_DEPTH   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int BW = $clog2(BUF_DEPTH);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_WR, S_RD} st_t;

  logic [1:0] scl_s, sda_s;
  logic       scl_p, sda_p;
  wire scl = scl_s[1];
  wire sda = sda_s[1];
  wire scl_rise = scl & ~scl_p;
  wire scl_fall = ~scl & scl_p;
  wire start_c  = scl & scl_p & sda_p & ~sda;
  wire stop_c   = scl & scl_p & ~sda_p & sda;

  st_t         st;
  logic [3:0]  bitcnt;
  logic        ackph, rw;
  logic [7:0]  sr, ptr, base;
  logic [7:0]  mem [256];
  logic [7:0]  wbuf [BUF_DEPTH];
  logic [BW-1:0] head;
  logic [BW:0] nkept;
  logic [CW-1:0] prog_cnt;

  wire       busy = prog_cnt != '0;
  wire [2:0] bsel = 3'(4'd7 - bitcnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11; scl_p <= 1'b1; sda_p <= 1'b1;
      st <= S_IDLE; bitcnt <= '0; ackph <= 1'b0; rw <= 1'b0;
      sr <= '0; ptr <= '0; base <= '0; head <= '0; nkept <= '0;
      prog_cnt <= '0; sda_oe <= 1'b0;
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      for (int i = 0; i < BUF_DEPTH; i++) wbuf[i] <= '0;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_p <= scl;
      sda_p <= sda;
      if (busy) prog_cnt <= prog_cnt - CW'(1);
      if (stop_c) begin
        if (st == S_WR && nkept != '0) begin
          for (int i = 0; i < BUF_DEPTH; i++)
            if (i < int'(nkept))
              mem[base + 8'(i)] <= wbuf[head - BW'(nkept) + BW'(i)];
          ptr <= base + 8'(nkept);
          prog_cnt <= CW'(PROG_CYCLES);
        end
        st <= S_IDLE; ackph <= 1'b0; sda_oe <= 1'b0;
      end else if (start_c) begin
        st <= S_CTRL; bitcnt <= '0; ackph <= 1'b0; sda_oe <= 1'b0;
      end else if (st == S_RD) begin
        if (scl_rise && !ackph && bitcnt < 4'd8) bitcnt <= bitcnt + 4'd1;
        if (scl_rise && ackph && sda) begin
          st <= S_IDLE; ackph <= 1'b0;
        end
        if (scl_fall) begin
          if (ackph) begin
            ackph <= 1'b0; bitcnt <= '0; sda_oe <= ~mem[ptr][7];
          end else if (bitcnt == 4'd8) begin
            ackph <= 1'b1; sda_oe <= 1'b0; ptr <= ptr + 8'd1;
          end else begin
            sda_oe <= ~mem[ptr][bsel];
          end
        end
      end else if (st != S_IDLE) begin
        if (scl_rise && !ackph && bitcnt < 4'd8) begin
          sr <= {sr[6:0], sda};
          bitcnt <= bitcnt + 4'd1;
        end
        if (scl_fall && ackph) begin
          ackph <= 1'b0; bitcnt <= '0; sda_oe <= 1'b0;
          if (st == S_CTRL) begin
            st <= rw ? S_RD : S_ADDR;
            if (rw) sda_oe <= ~mem[ptr][7];
          end else if (st == S_ADDR) begin
            st <= S_WR;
          end
        end else if (scl_fall && bitcnt == 4'd8) begin
          case (st)
            S_CTRL: begin
              if (sr[7:4] == 4'b1010 && !busy) begin
                ackph <= 1'b1; sda_oe <= 1'b1; rw <= sr[0];
              end else begin
                st <= S_IDLE;
              end
            end
            S_ADDR: begin
              ackph <= 1'b1; sda_oe <= 1'b1;
              base <= sr; ptr <= sr; head <= '0; nkept <= '0;
            end
            default: begin
              ackph <= 1'b1; sda_oe <= 1'b1;
              wbuf[head] <= sr;
              head <= head + BW'(1);
              if (nkept < (BW+1)'(BUF_DEPTH)) nkept <= nkept + (BW+1)'(1);
            end
          endcase
        end
      end
    end
  end

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (!sda_oe && st == S_IDLE));

  // R3
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RD && ackph && scl && scl_p) |-> $stable(sda_oe));

  // R8
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && ackph && scl_rise && sda && !stop_c) |=> (!sda_oe && st == S_IDLE));

  // R9
  busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stop_c) |=> (prog_cnt == $past(prog_cnt) - CW'(1)));

  // R9
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == S_CTRL && scl_fall && bitcnt == 4'd8 && !ackph && !stop_c && !start_c)
      |=> !sda_oe);
endmodule

// File: tb/sim_i2c_eeprom_slave.sv
module sim_i2c_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam int PROG = 400;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire line = sda_m & ~sda_oe;

  i2c_eeprom_slave #(.PROG_CYCLES(PROG), .BUF_DEPTH(16)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line), .sda_oe(sda_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, glitch = 0;
  logic [7:0] model [256];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(output bit s);
    bit a, c;
    wq(Q); scl = 1'b1;
    wq(1); a = line;
    wq(Q-1); s = line;
    wq(Q-1); c = line;
    wq(1); scl = 1'b0;
    if (a != s || s != c) glitch++;
    wq(1);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) begin sda_m = b[i]; pulse(s); end
    sda_m = 1'b1; pulse(s); ack = ~s;
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    bit s;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin pulse(s); b[i] = s; end
    sda_m = ~mack; pulse(s); sda_m = 1'b1;
  endtask

  task automatic rd_check(input logic [7:0] a, input int n, input string req);
    bit ack; logic [7:0] b;
    i2c_start(); wbyte(8'hA0, ack); chk(ack, req, ack, 1);
    wbyte(a, ack); chk(ack, req, ack, 1);
    i2c_start(); wbyte(8'hA1, ack); chk(ack, req, ack, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(k != n-1, b);
      chk(b == model[8'(a + k)], req, b, model[8'(a + k)]);
    end
    i2c_stop();
  endtask

  task automatic cur_read(output logic [7:0] b, output bit ack);
    i2c_start(); wbyte(8'hA1, ack);
    if (ack) rbyte(1'b0, b); else b = 8'hxx;
    i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ack, s, hi;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    wq(5); rst_n = 1'b1; wq(5);

    // R10: released SDA, zero memory at pointer 0
    chk(sda_oe == 1'b0, "R10", sda_oe, 0);
    cur_read(b, ack);
    chk(ack, "R10", ack, 1);
    chk(b == 8'h00, "R10", b, 0);

    // R2: wrong upper nibble is refused and the bus then ignored
    i2c_start(); wbyte(8'h90, ack); chk(!ack, "R2", ack, 0);
    wbyte(8'h00, ack); chk(!ack, "R2", ack, 0);
    i2c_stop();
    i2c_start(); wbyte(8'hB1, ack); chk(!ack, "R2", ack, 0);
    i2c_stop();
    // R2: bits 3:1 are don't care
    for (int x = 0; x < 8; x++) begin
      i2c_start(); wbyte({4'hA, 3'(x), 1'b0}, ack); chk(ack, "R2", ack, 1);
      i2c_stop();
    end

    // R4: fill the whole array page by page
    for (int p = 0; p < 16; p++) begin
      i2c_start(); wbyte(8'hA0, ack); chk(ack, "R4", ack, 1);
      wbyte(8'(p * 16), ack);
      for (int k = 0; k < 16; k++) begin
        b = 8'((p * 16 + k) * 37 + 5);
        wbyte(b, ack); chk(ack, "R4", ack, 1);
        model[8'(p * 16 + k)] = b;
      end
      i2c_stop(); wq(PROG + 20);
    end
    // R7: sequential read of all bytes plus one wrap past 255
    rd_check(8'h00, 257, "R7");

    // R9: while programming, control bytes are refused and data ignored
    i2c_start(); wbyte(8'hA0, ack); wbyte(8'h40, ack); wbyte(8'h11, ack);
    i2c_stop(); model[8'h40] = 8'h11;
    i2c_start(); wbyte(8'hA0, ack); chk(!ack, "R9", ack, 0);
    wbyte(8'h41, ack); wbyte(8'h99, ack); chk(!ack, "R9", ack, 0);
    i2c_stop(); wq(PROG + 20);
    rd_check(8'h40, 2, "R9");

    // R5: 20 bytes at 0xF8, only the last 16 kept, wrapping into 0x00..0x07
    i2c_start(); wbyte(8'hA0, ack); wbyte(8'hF8, ack);
    for (int k = 0; k < 20; k++) begin
      wbyte(8'hC0 + 8'(k), ack); chk(ack, "R5", ack, 1);
    end
    i2c_stop();
    for (int k = 4; k < 20; k++) model[8'(8'hF8 + k - 4)] = 8'hC0 + 8'(k);
    wq(PROG + 20);
    rd_check(8'hF7, 18, "R5");

    // R6: address-only write, no busy interval
    i2c_start(); wbyte(8'hA0, ack); wbyte(8'h33, ack); chk(ack, "R6", ack, 1);
    i2c_stop();
    cur_read(b, ack);
    chk(ack, "R6", ack, 1);
    chk(b == model[8'h33], "R6", b, model[8'h33]);
    // R7: pointer carries to next transaction
    cur_read(b, ack);
    chk(b == model[8'h34], "R7", b, model[8'h34]);

    // R4: pointer after a commit is address plus kept count
    i2c_start(); wbyte(8'hA0, ack); wbyte(8'h50, ack);
    wbyte(8'h5A, ack); wbyte(8'hA5, ack); i2c_stop();
    model[8'h50] = 8'h5A; model[8'h51] = 8'hA5;
    wq(PROG + 20);
    cur_read(b, ack);
    chk(b == model[8'h52], "R4", b, model[8'h52]);

    // R8: master NACK releases SDA
    i2c_start(); wbyte(8'hA0, ack); wbyte(8'h00, ack);
    i2c_start(); wbyte(8'hA1, ack); rbyte(1'b0, b);
    hi = 1'b1;
    sda_m = 1'b1;
    for (int k = 0; k < 9; k++) begin pulse(s); hi &= s; end
    chk(hi, "R8", hi, 1);
    i2c_stop();

    // R1: START in the middle of a data byte restarts the transaction
    i2c_start(); wbyte(8'hA0, ack); wbyte(8'h60, ack);
    sda_m = 1'b0; pulse(s); sda_m = 1'b1; pulse(s); sda_m = 1'b0; pulse(s);
    i2c_start(); wbyte(8'hA1, ack); chk(ack, "R1", ack, 1);
    rbyte(1'b0, b);
    chk(b == model[8'h60], "R1", b, model[8'h60]);
    i2c_stop();
    wq(2);
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);

    // R3: every high phase held one SDA level throughout
    chk(glitch == 0, "R3", glitch, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule